// File: doc/BRIEF.md
# Transmit FIFO with Watermark Request

This block is the transmit-side buffer of a serial port. A bus writer (a processor or a DMA engine) pushes data words into a sixteen-stage first-in first-out store. A serial shifter takes them out from the head. Each word leaves in the order it arrived. The head word is always visible on `pop_data`, and a pop consumes it.

A 16-bit control register holds two fields:

- A 3-bit watermark code. It chooses how many stages must be empty before the block asks the writer for more data.
- A read-only 5-bit free-space count. It runs from 16 when the store is empty down to 0 when it is full.

The request appears both on the `data_req` pin and as bit 0 of a separate status register. The status register also keeps two sticky error bits, one for a push into a full store and one for a pop from an empty store.

The fill level is tracked by a three-state machine with these states and transitions:

| State | Meaning |
|---|---|
| `LV_EMPTY` | all stages free |
| `LV_PART` | some stages used |
| `LV_FULL` | no stage free |

| Transition | From | To | Condition |
|---|---|---|---|
| `T_FILL_START` | `LV_EMPTY` | `LV_PART` | an accepted lone push |
| `T_FILL_TOP` | `LV_PART` | `LV_FULL` | a lone push while one stage is free |
| `T_DRAIN_TOP` | `LV_FULL` | `LV_PART` | an accepted lone pop |
| `T_DRAIN_END` | `LV_PART` | `LV_EMPTY` | a lone pop while one stage is used |

Every other case holds the current state.

Top module: `txfifo_wm`

## Requirements
- R1: After reset, the control register reads 16'h1000: watermark 000 and free count 16. The status register reads 16'h0001, and `data_req` is 1.
- R2: Control register layout (`reg_addr`=0):
  - bits 15:13 are the writable watermark code;
  - bits 12:8 are the read-only free count;
  - bits 7:0 read 0.
  Writes to bits 12:0 have no effect, and writes to `reg_addr`=1 have no effect.
- R3: An accepted lone push lowers the free count by 1, and an accepted lone pop raises it by 1. A push and a pop accepted in the same cycle leave it unchanged. The count stays within 0..16.
- R4: Words leave in push order. `pop_data` shows the head word before the pop that removes it, and this order holds also across same-cycle push and pop.
- R5: A push while the free count is 0 is ignored, even if a pop occurs in the same cycle. It sets sticky status bit 1 (overflow), which is cleared only by reset.
- R6: A pop while the free count is 16 is ignored, even if a push occurs in the same cycle. It sets sticky status bit 2 (underflow), which is cleared only by reset.
- R7: Watermark codes 100, 101, 110 and 111 raise the request when the free count is at least 12, 8, 4 and 1 respectively.
- R8: Watermark code 000, and the prohibited codes 001, 010 and 011, raise the request only when the free count is 16.
- R9: `data_req` and status bit 0 follow the current free count with no added delay. Status bits 15:3 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low synchronous reset |
| push | input | 1 | writer stores `push_data` this cycle |
| push_data | input | DATA_W | word to store |
| pop | input | 1 | shifter removes the head word this cycle |
| pop_data | output | DATA_W | current head word |
| reg_addr | input | 1 | 0 selects control, 1 selects status |
| reg_wr | input | 1 | register write strobe |
| reg_wdata | input | 16 | register write data |
| reg_rdata | output | 16 | register read data for `reg_addr` |
| data_req | output | 1 | transfer request to the writer |

## Verification
A push and a pop can fall in the same cycle. The interesting cases are when the store is empty, partly filled or full, because only one of the two may then be accepted. The bench provokes each case with both strobes raised on one edge. It judges the result by the free count read back through the control register, by the sticky error bits in the status register, and by draining the store to confirm that the word order survived. The watermark compare is swept over every code at every fill level from 0 to 16, against thresholds the bench works out itself.

// File: rtl/txf_pkg.sv
package txf_pkg;

    typedef enum logic [1:0] {
        LV_EMPTY = 2'd0,
        LV_PART  = 2'd1,
        LV_FULL  = 2'd2
    } lvl_state_t;

    localparam int REG_W   = 16;
    localparam int WM_W    = 3;
    localparam int FREE_W  = 5;
    localparam int WM_LSB  = 13;
    localparam int FREE_LSB = 8;

    localparam logic [WM_W-1:0] WM_ALL  = 3'b000;
    localparam logic [WM_W-1:0] WM_3Q   = 3'b100;
    localparam logic [WM_W-1:0] WM_HALF = 3'b101;
    localparam logic [WM_W-1:0] WM_1Q   = 3'b110;
    localparam logic [WM_W-1:0] WM_ANY  = 3'b111;

endpackage

// File: rtl/txf_store.sv
module txf_store #(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push_ok,
    input  logic              pop_ok,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] head
);
    localparam int PTR_W = $clog2(DEPTH);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0]  wr_ptr;
    logic [PTR_W-1:0]  rd_ptr;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        if (int'(p) == DEPTH - 1) begin
            return '0;
        end
        return p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
        end else begin
            if (push_ok) begin
                wr_ptr <= bump(wr_ptr);
            end
            if (pop_ok) begin
                rd_ptr <= bump(rd_ptr);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (push_ok) begin
            mem[wr_ptr] <= wdata;
        end
    end

    assign head = mem[rd_ptr];
endmodule

// File: rtl/txf_level.sv
module txf_level
    import txf_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic             pop,
    output logic             push_ok,
    output logic             pop_ok,
    output logic             ovf_evt,
    output logic             udf_evt,
    output logic [CNT_W-1:0] free_cnt
);
    lvl_state_t       state_q;
    lvl_state_t       state_d;
    logic [CNT_W-1:0] free_d;

    // state register and free counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= LV_EMPTY;
            free_cnt <= CNT_W'(DEPTH);
        end else begin
            state_q  <= state_d;
            free_cnt <= free_d;
        end
    end

    // outputs, next state and next count
    always_comb begin
        push_ok = push && (state_q != LV_FULL);
        pop_ok  = pop && (state_q != LV_EMPTY);
        ovf_evt = push && (state_q == LV_FULL);
        udf_evt = pop && (state_q == LV_EMPTY);
        free_d  = free_cnt;
        state_d = state_q;
        if (push_ok && !pop_ok) begin
            free_d = free_cnt - 1'b1;
        end else if (pop_ok && !push_ok) begin
            free_d = free_cnt + 1'b1;
        end
        unique case (state_q)
            LV_EMPTY: begin
                // T_FILL_START
                if (push_ok) begin
                    state_d = (DEPTH == 1) ? LV_FULL : LV_PART;
                end
            end
            LV_PART: begin
                if (push_ok && !pop_ok && free_cnt == CNT_W'(1)) begin
                    state_d = LV_FULL;          // T_FILL_TOP
                end else if (pop_ok && !push_ok && free_cnt == CNT_W'(DEPTH - 1)) begin
                    state_d = LV_EMPTY;         // T_DRAIN_END
                end
            end
            LV_FULL: begin
                // T_DRAIN_TOP
                if (pop_ok) begin
                    state_d = (DEPTH == 1) ? LV_EMPTY : LV_PART;
                end
            end
            default: state_d = LV_EMPTY;
        endcase
    end
endmodule

// File: rtl/txf_reqgen.sv
module txf_reqgen
    import txf_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic [WM_W-1:0]  wm_code,
    input  logic [CNT_W-1:0] free_cnt,
    output logic             req
);
    localparam logic [CNT_W-1:0] THR_ALL  = CNT_W'(DEPTH);
    localparam logic [CNT_W-1:0] THR_3Q   = CNT_W'((DEPTH * 3) / 4);
    localparam logic [CNT_W-1:0] THR_HALF = CNT_W'(DEPTH / 2);
    localparam logic [CNT_W-1:0] THR_1Q   = CNT_W'(DEPTH / 4);
    localparam logic [CNT_W-1:0] THR_ANY  = CNT_W'(1);

    logic [CNT_W-1:0] thr;

    always_comb begin
        unique case (wm_code)
            WM_3Q:   thr = THR_3Q;
            WM_HALF: thr = THR_HALF;
            WM_1Q:   thr = THR_1Q;
            WM_ANY:  thr = THR_ANY;
            default: thr = THR_ALL;   // 000 and the prohibited codes
        endcase
    end

    assign req = (free_cnt >= thr);
endmodule

// File: rtl/txfifo_wm.sv
module txfifo_wm
    import txf_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [DATA_W-1:0] push_data,
    input  logic              pop,
    output logic [DATA_W-1:0] pop_data,
    input  logic              reg_addr,
    input  logic              reg_wr,
    input  logic [15:0]       reg_wdata,
    output logic [15:0]       reg_rdata,
    output logic              data_req
);
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic             push_ok;
    logic             pop_ok;
    logic             ovf_evt;
    logic             udf_evt;
    logic [CNT_W-1:0] free_cnt;
    logic [WM_W-1:0]  wm_q;
    logic             ovf_q;
    logic             udf_q;

    txf_level #(.DEPTH(DEPTH)) level_i (
        .clk(clk), .rst_n(rst_n), .push(push), .pop(pop),
        .push_ok(push_ok), .pop_ok(pop_ok),
        .ovf_evt(ovf_evt), .udf_evt(udf_evt), .free_cnt(free_cnt)
    );

    txf_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) store_i (
        .clk(clk), .rst_n(rst_n), .push_ok(push_ok), .pop_ok(pop_ok),
        .wdata(push_data), .head(pop_data)
    );

    txf_reqgen #(.DEPTH(DEPTH)) req_i (
        .wm_code(wm_q), .free_cnt(free_cnt), .req(data_req)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wm_q  <= WM_ALL;
            ovf_q <= 1'b0;
            udf_q <= 1'b0;
        end else begin
            if (reg_wr && !reg_addr) begin
                wm_q <= reg_wdata[WM_LSB +: WM_W];
            end
            if (ovf_evt) begin
                ovf_q <= 1'b1;
            end
            if (udf_evt) begin
                udf_q <= 1'b1;
            end
        end
    end

    always_comb begin
        reg_rdata = '0;
        if (!reg_addr) begin
            reg_rdata[WM_LSB +: WM_W]     = wm_q;
            reg_rdata[FREE_LSB +: FREE_W] = FREE_W'(free_cnt);
        end else begin
            reg_rdata[0] = data_req;
            reg_rdata[1] = ovf_q;
            reg_rdata[2] = udf_q;
        end
    end
endmodule

// File: rtl/txfifo_wm_chk.sv
module txfifo_wm_chk #(
    parameter int DEPTH = 16,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             push,
    input logic             pop,
    input logic [CNT_W-1:0] free_cnt,
    input logic [2:0]       wm_code,
    input logic             data_req,
    input logic             ovf,
    input logic             udf
);
    // R3
    free_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        free_cnt <= CNT_W'(DEPTH));

    // R3
    pair_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push && pop && free_cnt != 0 && free_cnt != CNT_W'(DEPTH)) |=> $stable(free_cnt));

    // R5
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !pop && free_cnt == 0) |=> (free_cnt == 0 && ovf));

    // R6
    no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !push && free_cnt == CNT_W'(DEPTH)) |=> (free_cnt == CNT_W'(DEPTH) && udf));

    // R5
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |=> ovf);

    // R6
    udf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        udf |=> udf);

    // R8
    req_strict_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wm_code[2] |-> (data_req == (free_cnt == CNT_W'(DEPTH))));

    // R7
    req_any_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wm_code == 3'b111) |-> (data_req == (free_cnt != 0)));
endmodule

bind txfifo_wm txfifo_wm_chk #(.DEPTH(DEPTH)) chk_i (
    .clk(clk), .rst_n(rst_n), .push(push), .pop(pop),
    .free_cnt(free_cnt), .wm_code(wm_q), .data_req(data_req),
    .ovf(ovf_q), .udf(udf_q)
);

// File: tb/txfifo_wm_tb_top.sv
module txfifo_wm_tb_top;
    localparam int DATA_W = 32;
    localparam int DEPTH  = 16;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              push = 1'b0;
    logic [DATA_W-1:0] push_data = '0;
    logic              pop = 1'b0;
    logic [DATA_W-1:0] pop_data;
    logic              reg_addr = 1'b0;
    logic              reg_wr = 1'b0;
    logic [15:0]       reg_wdata = '0;
    logic [15:0]       reg_rdata;
    logic              data_req;

    int checks = 0;
    int fails  = 0;
    int m_free = DEPTH;
    logic [2:0] m_wm = 3'b000;
    logic m_ovf = 1'b0;
    logic m_udf = 1'b0;
    logic [DATA_W-1:0] m_q [$];

    always #5 clk = ~clk;

    txfifo_wm #(.DATA_W(DATA_W), .DEPTH(DEPTH)) dut_i (
        .clk(clk), .rst_n(rst_n), .push(push), .push_data(push_data),
        .pop(pop), .pop_data(pop_data), .reg_addr(reg_addr),
        .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .data_req(data_req)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic int thr_of(input logic [2:0] c);
        case (c)
            3'b100:  return 12;
            3'b101:  return 8;
            3'b110:  return 4;
            3'b111:  return 1;
            default: return 16;
        endcase
    endfunction

    task automatic cyc(input logic pu, input logic po, input logic [DATA_W-1:0] d);
        logic pok;
        logic uok;
        @(negedge clk);
        pok = po && (m_free != DEPTH);
        uok = pu && (m_free != 0);
        if (pok) chk("R4 head before pop", pop_data, m_q[0]);
        push = pu; pop = po; push_data = d;
        @(posedge clk);
        #1;
        push = 1'b0; pop = 1'b0;
        if (pu && !uok) m_ovf = 1'b1;
        if (po && !pok) m_udf = 1'b1;
        if (pok) void'(m_q.pop_front());
        if (uok) m_q.push_back(d);
        if (uok && !pok) m_free--;
        if (pok && !uok) m_free++;
    endtask

    task automatic reg_write(input logic a, input logic [15:0] v);
        @(negedge clk);
        reg_addr = a; reg_wr = 1'b1; reg_wdata = v;
        @(posedge clk);
        #1;
        reg_wr = 1'b0;
        if (!a) m_wm = v[15:13];
    endtask

    task automatic check_regs(input string tg);
        logic req_e;
        req_e = (m_free >= thr_of(m_wm));
        reg_addr = 1'b0;
        #1;
        chk("R2 R3 control readback", reg_rdata, {m_wm, 5'(m_free), 8'h00});
        reg_addr = 1'b1;
        #1;
        chk(tg, reg_rdata, {13'h0, m_udf, m_ovf, req_e});
        chk("R9 data_req pin", data_req, req_e);
    endtask

    initial begin
        #2_000_000;
        checks++; fails++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        #1;
        // R1 reset state
        reg_addr = 1'b0; #1;
        chk("R1 control after reset", reg_rdata, 16'h1000);
        reg_addr = 1'b1; #1;
        chk("R1 status after reset", reg_rdata, 16'h0001);
        chk("R1 data_req after reset", data_req, 1'b1);

        // R2 status write ignored
        reg_write(1'b1, 16'hFFFF);
        check_regs("R2 status write ignored");

        // R7 R8 sweep all codes over all levels
        for (int c = 0; c < 8; c++) begin
            reg_write(1'b0, {3'(c), 13'h1FFF});
            for (int lv = 0; lv <= DEPTH; lv++) begin
                check_regs(c[2] ? "R7 status at level" : "R8 status at level");
                if (lv < DEPTH) cyc(1'b1, 1'b0, 32'(c * 256 + lv + 1));
            end
            cyc(1'b1, 1'b0, 32'hDEAD_BEEF);          // R5 push when full
            check_regs("R5 overflow flag");
            for (int k = 0; k < DEPTH; k++) begin
                cyc(1'b0, 1'b1, '0);                   // R4 order
                check_regs(c[2] ? "R7 drain" : "R8 drain");
            end
            cyc(1'b0, 1'b1, '0);                       // R6 pop when empty
            check_regs("R6 underflow flag");
        end

        // R3 simultaneous push and pop at mid level
        reg_write(1'b0, 16'hA000);
        for (int k = 0; k < 5; k++) cyc(1'b1, 1'b0, 32'(100 + k));
        cyc(1'b1, 1'b1, 32'd200);
        check_regs("R3 pair mid");
        cyc(1'b1, 1'b1, 32'd201);
        check_regs("R3 pair mid again");
        for (int k = 0; k < 5; k++) cyc(1'b0, 1'b1, '0);
        check_regs("R4 drained after pairs");

        // R6 pair while empty: push taken, pop ignored
        cyc(1'b1, 1'b1, 32'd300);
        check_regs("R6 pair empty");
        // fill to full, then R5 pair while full: pop taken, push ignored
        for (int k = 0; k < DEPTH - 1; k++) cyc(1'b1, 1'b0, 32'(400 + k));
        check_regs("R3 full");
        cyc(1'b1, 1'b1, 32'd999);
        check_regs("R5 pair full");
        for (int k = 0; k < DEPTH - 1; k++) cyc(1'b0, 1'b1, '0);
        check_regs("R4 final empty");

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule